// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a synchronous host port and an asynchronous extended-data-out dynamic RAM. Each host request carries an 18-bit word address, a direction flag and write data. The controller splits the address into a row half and a column half and presents them one after the other on a shared 9-bit address bus. It sequences the active-low row strobe, column strobe, write enable and output enable. It drives the data bus only while it writes. Every analog minimum of the memory is given as a whole number of clock cycles through a parameter.

After a row is opened it stays open. Later requests to the same row cost only a column cycle. A request to a different row closes the page, waits out the precharge time and opens the new row. The page also closes by itself after a parameterised number of cycles with no request. Each column address is placed on the bus while the column strobe is still high, so the access time counts from a valid address. Writes lower write enable before the column strobe falls, so the memory never drives its data pins during a write.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row is address bits [17:9] and the column is bits [8:0]. The row is on the memory address bus when the row strobe falls, and the column is on it when the column strobe falls.
- R2: Once the row strobe falls, it stays low for at least T_RAS cycles before it rises.
- R3: The row strobe stays high for at least T_RP cycles before it falls again, including after reset. During reset and until the first precharge ends, all four strobes are high (inactive), ready is low and no read data is flagged.
- R4: Between two column cycles in the same page, the column strobe stays high for at least T_CP cycles.
- R5: A read keeps write enable high and drives output enable low while the column strobe is low. Data is sampled after the largest of the access delays. From an idle (closed) state the first read data appears T_RCD+T_ASC+L1+1 cycles after the request is accepted, where L1 = max(T_CAS, T_CAC, T_OAC, T_CAA-T_ASC, T_RAC-T_RCD-T_ASC, T_AR-T_RCD-T_ASC). With the default parameters this is 7 cycles.
- R6: A write drives write enable low and places the data on the bus at least one cycle before the column strobe falls, and keeps output enable high. A write produces no read-data pulse.
- R7: A request to the open row issues no new row cycle. A read hit returns data T_ASC+L2+1 cycles after acceptance, where L2 = max(T_CAS, T_CAC, T_OAC, T_CAA-T_ASC). With the default parameters this is 4 cycles.
- R8: Each column address is on the bus for T_ASC cycles with the column strobe high before the strobe falls, and it stays unchanged while the strobe is low.
- R9: A request to a different row raises the row strobe, precharges for T_RP cycles and reopens the row. When T_RAS has already elapsed, a read miss returns data 1+T_RP+T_RCD+T_ASC+L1+1 cycles after acceptance (12 with the default parameters).
- R10: After T_IDLE cycles in the open page with no request, the row strobe rises. The next read then pays the full idle-state latency of R5.
- R11: Ready is high only in the idle state or in the open page once the column precharge has been met. It is low in the cycle after an accept. Read data valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller accepts a request this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address, row in [17:9], column in [8:0] |
| req_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | One-cycle pulse with read data |
| rd_data_o | output | 16 | Read data |
| dram_addr_o | output | 9 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_io | inout | 16 | Bidirectional data bus |

## Verification
The assertions assume that req_addr_i, req_we_i and req_wdata_i are stable whenever the host holds req_valid_i in a cycle where ready is high. They also assume that the memory drives the data bus only while output enable and the column strobe are both low with write enable high. The stimulus changes host inputs only on the falling clock edge and drops valid in the cycle after an accept. The memory model in the bench drives the bus only under that strobe condition. The timing parameters stay at their defaults, where T_ASC is at least one cycle. This is what makes the early-write order hold.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_PRECH, ST_IDLE, ST_ROW, ST_COLA, ST_COLS, ST_PAGE, ST_CLOSE
  } edo_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int TW      = 4,
  parameter int RST_VAL = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= TW'(RST_VAL);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int ROW_W  = 9,
  parameter int T_IDLE = 16,
  localparam int IW    = $clog2(T_IDLE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_row_i,
  input  logic             in_close_i,
  input  logic             in_page_i,
  input  logic             accept_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] req_row_i,
  output logic             hit_o,
  output logic             timeout_o
);
  logic [ROW_W-1:0] open_row_q;
  logic             open_q;
  logic [IW-1:0]    idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_row_q <= '0;
      open_q     <= 1'b0;
    end else if (in_row_i) begin
      open_row_q <= row_i;
      open_q     <= 1'b1;
    end else if (in_close_i) begin
      open_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       idle_q <= '0;
    else if (!in_page_i || accept_i)   idle_q <= '0;
    else if (!timeout_o)               idle_q <= idle_q + 1'b1;
  end

  assign hit_o     = open_q && (req_row_i == open_row_q);
  assign timeout_o = (idle_q >= IW'(T_IDLE - 1));
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DW     = 16,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 4,
  parameter int T_RCD  = 2,
  parameter int T_ASC  = 1,
  parameter int T_CAS  = 2,
  parameter int T_CP   = 2,
  parameter int T_CAC  = 2,
  parameter int T_CAA  = 3,
  parameter int T_RAC  = 6,
  parameter int T_OAC  = 2,
  parameter int T_AR   = 5,
  parameter int T_IDLE = 16,
  localparam int AW    = ROW_W + COL_W,
  localparam int MAW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_we_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           rd_valid_o,
  output logic [DW-1:0]  rd_data_o,
  output logic [MAW-1:0] dram_addr_o,
  output logic           dram_ras_no,
  output logic           dram_cas_no,
  output logic           dram_we_no,
  output logic           dram_oe_no,
  output logic           dq_oe_o,
  output logic [DW-1:0]  dq_o,
  input  logic [DW-1:0]  dq_i
);
  // strobe-low lengths of first and page column cycles
  localparam int L_PAGE  = imax(imax(T_CAS, T_CAC), imax(T_OAC, T_CAA - T_ASC));
  localparam int L_FIRST = imax(L_PAGE, imax(T_RAC - T_RCD - T_ASC, T_AR - T_RCD - T_ASC));
  localparam int CP_WAIT = imax(1, T_CP - T_ASC);
  localparam int TMAX    = imax(imax(imax(T_RAS, T_RP), imax(T_RCD, T_ASC)),
                                imax(imax(L_FIRST, CP_WAIT), T_CAS));
  localparam int TW      = $clog2(TMAX + 1) + 1;

  edo_state_e       state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             we_q, pend_q, first_q;
  logic [DW-1:0]    wdata_q, rd_data_q;
  logic             rd_valid_q;

  logic          ph_load, ph_done, ras_load, ras_done;
  logic [TW-1:0] ph_val, ras_val;
  logic          hit, timeout, accept, cap, set_pend;

  edo_timer #(.TW(TW), .RST_VAL(0)) u_ph_tmr (
    .clk_i, .rst_ni, .load_i(ph_load), .val_i(ph_val), .done_o(ph_done)
  );

  // row-strobe low/high minimums share one timer
  edo_timer #(.TW(TW), .RST_VAL(T_RP - 1)) u_ras_tmr (
    .clk_i, .rst_ni, .load_i(ras_load), .val_i(ras_val), .done_o(ras_done)
  );

  edo_row_track #(.ROW_W(ROW_W), .T_IDLE(T_IDLE)) u_track (
    .clk_i, .rst_ni,
    .in_row_i   (state_q == ST_ROW),
    .in_close_i (state_q == ST_CLOSE),
    .in_page_i  (state_q == ST_PAGE),
    .accept_i   (accept),
    .row_i      (row_q),
    .req_row_i  (req_addr_i[AW-1:COL_W]),
    .hit_o      (hit),
    .timeout_o  (timeout)
  );

  assign req_ready_o = (state_q == ST_IDLE) ||
                       (state_q == ST_PAGE && ph_done && !timeout);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d  = state_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    ras_load = 1'b0;
    ras_val  = '0;
    cap      = 1'b0;
    set_pend = 1'b0;
    unique case (state_q)
      ST_PRECH: if (ras_done) begin
        if (pend_q) begin
          state_d  = ST_ROW;
          ras_load = 1'b1; ras_val = TW'(T_RAS - 1);
          ph_load  = 1'b1; ph_val  = TW'(T_RCD - 1);
        end else begin
          state_d  = ST_IDLE;
        end
      end
      ST_IDLE: if (accept) begin
        state_d  = ST_ROW;
        ras_load = 1'b1; ras_val = TW'(T_RAS - 1);
        ph_load  = 1'b1; ph_val  = TW'(T_RCD - 1);
      end
      ST_ROW: if (ph_done) begin
        state_d = ST_COLA;
        ph_load = 1'b1; ph_val = TW'(T_ASC - 1);
      end
      ST_COLA: if (ph_done) begin
        state_d = ST_COLS;
        ph_load = 1'b1;
        if (first_q)   ph_val = TW'(L_FIRST - 1);
        else if (we_q) ph_val = TW'(T_CAS - 1);
        else           ph_val = TW'(L_PAGE - 1);
      end
      ST_COLS: if (ph_done) begin
        state_d = ST_PAGE;
        cap     = !we_q;
        ph_load = 1'b1; ph_val = TW'(CP_WAIT - 1);
      end
      ST_PAGE: begin
        if (timeout) begin
          state_d = ST_CLOSE;
        end else if (accept) begin
          if (hit) begin
            state_d = ST_COLA;
            ph_load = 1'b1; ph_val = TW'(T_ASC - 1);
          end else begin
            state_d  = ST_CLOSE;
            set_pend = 1'b1;
          end
        end
      end
      ST_CLOSE: if (ras_done) begin
        state_d  = ST_PRECH;
        ras_load = 1'b1; ras_val = TW'(T_RP - 1);
      end
      default: state_d = ST_PRECH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PRECH;
      row_q      <= '0;
      col_q      <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      pend_q     <= 1'b0;
      first_q    <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state_q    <= state_d;
      rd_valid_q <= cap;
      if (cap) rd_data_q <= dq_i;
      if (accept) begin
        row_q   <= req_addr_i[AW-1:COL_W];
        col_q   <= req_addr_i[COL_W-1:0];
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (set_pend)                                pend_q <= 1'b1;
      else if (state_q == ST_PRECH && state_d == ST_ROW) pend_q <= 1'b0;
      if (state_d == ST_ROW)                       first_q <= 1'b1;
      else if (state_q == ST_COLS)                 first_q <= 1'b0;
    end
  end

  logic col_phase;
  assign col_phase   = (state_q == ST_COLA) || (state_q == ST_COLS);
  assign dram_ras_no = (state_q == ST_PRECH) || (state_q == ST_IDLE);
  assign dram_cas_no = (state_q != ST_COLS);
  assign dram_we_no  = !(we_q && col_phase);
  assign dram_oe_no  = !(!we_q && state_q == ST_COLS);
  assign dram_addr_o = (state_q == ST_PRECH || state_q == ST_IDLE || state_q == ST_ROW)
                       ? MAW'(row_q) : MAW'(col_q);
  assign dq_oe_o     = we_q && col_phase;
  assign dq_o        = wdata_q;
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;

  // R2
  ras_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |-> $past(ras_done));
  // R3
  ras_prech_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> $past(ras_done));
  // R6
  early_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_we_no) |-> ($past(!dram_we_no) && dram_oe_no));
  // R5
  read_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> (dram_we_no && !dram_cas_no && !dq_oe_o));
  // R8
  col_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && !$fell(dram_cas_no)) |-> $stable(dram_addr_o));
  // R7
  cas_in_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  // R11
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  // R11
  ready_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> dram_cas_no);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DW     = 16,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 4,
  parameter int T_RCD  = 2,
  parameter int T_ASC  = 1,
  parameter int T_CAS  = 2,
  parameter int T_CP   = 2,
  parameter int T_CAC  = 2,
  parameter int T_CAA  = 3,
  parameter int T_RAC  = 6,
  parameter int T_OAC  = 2,
  parameter int T_AR   = 5,
  parameter int T_IDLE = 16,
  localparam int AW    = ROW_W + COL_W,
  localparam int MAW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_we_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           rd_valid_o,
  output logic [DW-1:0]  rd_data_o,
  output logic [MAW-1:0] dram_addr_o,
  output logic           dram_ras_no,
  output logic           dram_cas_no,
  output logic           dram_we_no,
  output logic           dram_oe_no,
  inout  wire  [DW-1:0]  dram_dq_io
);
  logic          dq_oe;
  logic [DW-1:0] dq_out;

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_ASC(T_ASC),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_CAC(T_CAC), .T_CAA(T_CAA),
    .T_RAC(T_RAC), .T_OAC(T_OAC), .T_AR(T_AR), .T_IDLE(T_IDLE)
  ) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i, .req_wdata_i,
    .rd_valid_o, .rd_data_o,
    .dram_addr_o, .dram_ras_no, .dram_cas_no, .dram_we_no, .dram_oe_no,
    .dq_oe_o (dq_oe),
    .dq_o    (dq_out),
    .dq_i    (dram_dq_io)
  );

  assign dram_dq_io = dq_oe ? dq_out : 'z;
endmodule

// File: tb/tb_edo_page_ctrl.sv
module tb_edo_page_ctrl;
  localparam int T_RAS = 6, T_RP = 4, T_RCD = 2, T_ASC = 1, T_CAS = 2, T_CP = 2;
  localparam int T_CAC = 2, T_CAA = 3, T_RAC = 6, T_OAC = 2, T_AR = 5, T_IDLE = 16;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int L2      = mx(mx(T_CAS, T_CAC), mx(T_OAC, T_CAA - T_ASC));
  localparam int L1      = mx(L2, mx(T_RAC - T_RCD - T_ASC, T_AR - T_RCD - T_ASC));
  localparam int LAT_IDL = T_RCD + T_ASC + L1 + 1;
  localparam int LAT_HIT = T_ASC + L2 + 1;
  localparam int LAT_MIS = 1 + T_RP + LAT_IDL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ready, rd_valid;
  logic [15:0] rd_data;
  logic [8:0]  ma;
  logic        ras_n, cas_n, we_n, oe_n;
  wire  [15:0] dq;

  always #4 clk = ~clk;

  edo_page_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .dram_addr_o(ma), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_oe_no(oe_n), .dram_dq_io(dq)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  logic [15:0] ref_mem [int];
  logic [15:0] dram_mem [int];
  logic [15:0] exp_q [$];
  logic [17:0] cur_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] rd_mem(ref logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0;
  endfunction

  // behavioural memory model
  logic        drv = 1'b0;
  logic [15:0] drv_val = '0;
  assign dq = drv ? drv_val : 'z;
  int   hi_cnt = 1000, lo_cnt = 0, cas_hi = 1000;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_rdv = 1'b0;
  logic [8:0] m_row = '0, m_col = '0, p_ma = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!ras_n && p_ras) begin
        chk(hi_cnt >= T_RP, "R3 precharge", hi_cnt, T_RP);
        chk(ma == cur_addr[17:9], "R1 row", ma, cur_addr[17:9]);
        m_row = ma;
      end
      if (ras_n && !p_ras) chk(lo_cnt >= T_RAS, "R2 ras low", lo_cnt, T_RAS);
      if (!cas_n && p_cas) begin
        chk(!ras_n, "R7 cas in ras", ras_n, 0);
        chk(cas_hi >= T_CP, "R4 cas precharge", cas_hi, T_CP);
        chk(ma == cur_addr[8:0], "R1 col", ma, cur_addr[8:0]);
        chk(ma == p_ma, "R8 col setup", ma, p_ma);
        m_col = ma;
        if (!we_n) begin
          chk(!p_we, "R6 early we", p_we, 0);
          chk(oe_n, "R6 oe high", oe_n, 1);
          dram_mem[{m_row, m_col}] = dq;
        end
      end
      if (!cas_n && !p_cas) chk(ma == m_col, "R8 col hold", ma, m_col);
      if (!oe_n) chk(we_n && !cas_n, "R5 read strobes", {we_n, cas_n}, 2'b10);
      if (!ras_n && !cas_n && !oe_n && we_n) begin
        drv     = 1'b1;
        drv_val = rd_mem(dram_mem, {m_row, m_col});
      end else drv = 1'b0;
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected rd_valid", 1, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R5 read data", rd_data, e);
        end
        chk(!p_rdv, "R11 pulse", p_rdv, 0);
      end
      hi_cnt = ras_n ? hi_cnt + 1 : 0;
      lo_cnt = ras_n ? 0 : lo_cnt + 1;
      cas_hi = cas_n ? cas_hi + 1 : 0;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_ma = ma; p_rdv = rd_valid;
    end
  end

  task automatic do_req(input bit w, input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    valid = 1'b1; we = w; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    cur_addr = a;
    if (w) ref_mem[a] = d;
    else   exp_q.push_back(rd_mem(ref_mem, a));
    #1 valid = 1'b0;
    @(negedge clk);
    chk(!ready, "R11 ready after accept", ready, 0);
  endtask

  task automatic rd_lat(input logic [17:0] a, input int exp_lat, input string tag);
    int lat;
    do_req(1'b0, a, '0);
    lat = 1;
    while (!rd_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, tag, lat, exp_lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R3 reset strobes", {ras_n, cas_n, we_n, oe_n}, 4'hf);
    chk(!ready && !rd_valid, "R3 reset ready", {ready, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ready && ras_n, "R3 precharge after reset", ready, 0);
    do_req(1'b1, {9'd5, 9'd10}, 16'h1234);
    rd_lat({9'd5, 9'd10}, LAT_HIT, "R7 hit latency");
    do_req(1'b1, {9'd5, 9'd11}, 16'hbeef);
    rd_lat({9'd5, 9'd11}, LAT_HIT, "R7 hit after write");
    rd_lat({9'd7, 9'd3}, LAT_MIS, "R9 miss latency");
    rd_lat({9'd5, 9'd11}, LAT_MIS, "R9 miss back");
    repeat (T_IDLE + 24) @(negedge clk);
    chk(ras_n, "R10 page closed", ras_n, 1);
    rd_lat({9'd5, 9'd10}, LAT_IDL, "R10 R5 idle latency");
    rd_lat({9'd5, 9'd511}, LAT_HIT, "R7 last column");
    for (int i = 0; i < 40; i++) begin
      logic [17:0] a;
      a = {($urandom % 3 == 0) ? 9'd7 : 9'd5, 9'($urandom % 8)};
      if ($urandom % 2) do_req(1'b1, a, 16'($urandom));
      else do_req(1'b0, a, '0);
    end
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule